// File: doc/BRIEF.md
# Exact Quire Multiply-Accumulate Unit

This block computes a dot product of low-precision operands with no rounding at any point. Each cycle it can take one activation and one weight that an upstream decoder has already split into sign, zero flag, NaR flag, signed scale and unsigned significand. It forms the full-width product, shifts it to a fixed binary point, and adds it in two's complement to a wide signed fixed-point register, the quire. The quire is sized so that a full-length dot product can neither overflow nor drop low-order bits.

A run starts with a clear. The clear loads the quire with an optional bias, aligned to the same binary point, and the product presented in that cycle is added as well. The operand flagged last ends the run. Two cycles later a one-cycle done pulse marks the quire output as the finished dot product. A sticky flag reports whether any operand in the run was NaR. Converting the quire back to a narrow format is left to a later stage.

Top module: `quire_mac`

## Requirements
- R1: After a synchronous active-low reset, `quire_out` is zero and `nar_out` and `done` are low.
- R2: A valid, non-zero, non-NaR operand pair adds exactly (-1)^(a_sign xor b_sign) × a_sig × b_sig × 2^(a_scale + b_scale − 2·SCALE_MIN) to the quire, counted in units of quire bit 0. There is no rounding.
- R3: The quire is QW = clog2(MAX_TERMS+1) + 2·SIG_W + 2·(SCALE_MAX − SCALE_MIN) + 1 bits wide (40 by default). MAX_TERMS products at the largest significand and scale, plus a bias, accumulate with no overflow for either sign.
- R4: `in_clear` replaces the quire with the aligned bias, (-1)^bias_sign × bias_sig × 2^(bias_scale − 2·SCALE_MIN + SIG_W − 1), or with zero when `bias_en` is low. A product valid in the same cycle is added on top.
- R5: `done` is high for exactly the cycle two cycles after the cycle in which `in_valid` and `in_last` are both high. `quire_out` then holds the run's total and keeps it until the next accepted operand or clear.
- R6: An operand flagged zero makes its pair contribute nothing, whatever its other fields hold.
- R7: An operand flagged NaR sets `nar_out`, which stays set until a clear. A clear reloads `nar_out` from the NaR flags of its own cycle. A NaR pair adds nothing to the quire.
- R8: Negative products and negative biases are added in two's complement, so the sign of the total can change several times during a run and end either way.
- R9: Cycles with `in_valid` low and `in_clear` low leave the quire and the NaR flag unchanged, whatever the operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_clear | input | 1 | Start a new run: load the bias or zero |
| in_last | input | 1 | This operand pair ends the run |
| a_sign | input | 1 | Activation sign |
| a_zero | input | 1 | Activation is zero |
| a_nar | input | 1 | Activation is NaR |
| a_scale | input | SCALE_W | Activation scale, signed |
| a_sig | input | SIG_W | Activation significand, unsigned |
| b_sign | input | 1 | Weight sign |
| b_zero | input | 1 | Weight is zero |
| b_nar | input | 1 | Weight is NaR |
| b_scale | input | SCALE_W | Weight scale, signed |
| b_sig | input | SIG_W | Weight significand, unsigned |
| bias_en | input | 1 | A bias is given with the clear |
| bias_sign | input | 1 | Bias sign |
| bias_scale | input | SCALE_W | Bias scale, signed |
| bias_sig | input | SIG_W | Bias significand, unsigned |
| quire_out | output | QW | Quire contents, two's complement |
| nar_out | output | 1 | Sticky NaR flag |
| done | output | 1 | Run result is on `quire_out` |

## Verification
Faults inside this block can only be seen through the quire value, the NaR flag and the done pulse. A misplaced shift, a dropped sign or a missing carry first shows up as a wrong `quire_out` on the done cycle. Because every product is exact, a single wrong bit anywhere in the run makes the total differ from the integer reference. A stale or wrongly cleared NaR flag, or a done pulse one cycle early or late, shows up within two cycles of the last operand. Idle cycles carrying garbage operands, and runs of maximum length at the extreme magnitudes, expose faults in the hold logic and in the width of the quire.

// File: rtl/quire_mac_pkg.sv
// Shared types and sizing helpers for the exact quire multiply-accumulate unit.
package quire_mac_pkg;

    // Control bits carried alongside a product into the accumulate stage.
    typedef struct packed {
        logic valid;
        logic clear;
        logic last;
        logic nar;
    } qm_ctl_t;

    // Quire width: term growth + full product span + sign bit.
    function automatic int qm_quire_width(input int terms, input int sig_w, input int span);
        return $clog2(terms + 1) + 2 * sig_w + 2 * span + 1;
    endfunction

endpackage

// File: rtl/quire_mac_mult.sv
// Exact product and alignment of one operand pair.
// Assumes scales lie within [SCALE_MIN, SCALE_MAX] and that SCALE_MIN <= 0.
// A pair containing a zero or NaR operand yields an all-zero product.
module quire_mac_mult #(
    parameter int SIG_W     = 4,
    parameter int SCALE_W   = 5,
    parameter int SCALE_MIN = -6,
    parameter int QW        = 40
) (
    input  logic                      a_sign,
    input  logic                      a_zero,
    input  logic                      a_nar,
    input  logic signed [SCALE_W-1:0] a_scale,
    input  logic        [SIG_W-1:0]   a_sig,
    input  logic                      b_sign,
    input  logic                      b_zero,
    input  logic                      b_nar,
    input  logic signed [SCALE_W-1:0] b_scale,
    input  logic        [SIG_W-1:0]   b_sig,
    output logic signed [QW-1:0]      prod_al
);
    localparam int PW   = 2 * SIG_W;
    localparam int SUMW = SCALE_W + 2;

    logic        [PW-1:0]   raw;
    logic signed [SUMW-1:0] shamt;
    logic        [QW-1:0]   mag;

    // Full-precision significand product and its shift to quire bit 0.
    always_comb begin
        raw   = PW'(a_sig) * PW'(b_sig);
        shamt = SUMW'(a_scale) + SUMW'(b_scale) - SUMW'(2 * SCALE_MIN);
        mag   = {{(QW - PW){1'b0}}, raw} << shamt;
    end

    // Apply the sign in two's complement, or suppress zero/NaR pairs.
    always_comb begin
        if (a_zero || b_zero || a_nar || b_nar) begin
            prod_al = '0;
        end else if (a_sign ^ b_sign) begin
            prod_al = -$signed(mag);
        end else begin
            prod_al = $signed(mag);
        end
    end
endmodule

// File: rtl/quire_mac_bias.sv
// Aligns the optional bias to the quire binary point.
// Assumes bias_scale lies within [SCALE_MIN, SCALE_MAX] and that SCALE_MIN <= 0.
module quire_mac_bias #(
    parameter int SIG_W     = 4,
    parameter int SCALE_W   = 5,
    parameter int SCALE_MIN = -6,
    parameter int QW        = 40
) (
    input  logic                      bias_en,
    input  logic                      bias_sign,
    input  logic signed [SCALE_W-1:0] bias_scale,
    input  logic        [SIG_W-1:0]   bias_sig,
    output logic signed [QW-1:0]      bias_al
);
    localparam int SUMW = SCALE_W + 2;

    logic signed [SUMW-1:0] shamt;
    logic        [QW-1:0]   mag;

    // Shift the significand so its weight matches quire bit 0.
    always_comb begin
        shamt = SUMW'(bias_scale) - SUMW'(2 * SCALE_MIN) + SUMW'(SIG_W - 1);
        mag   = {{(QW - SIG_W){1'b0}}, bias_sig} << shamt;
    end

    // Signed result, or zero when no bias is supplied.
    always_comb begin
        if (!bias_en) begin
            bias_al = '0;
        end else if (bias_sign) begin
            bias_al = -$signed(mag);
        end else begin
            bias_al = $signed(mag);
        end
    end
endmodule

// File: rtl/quire_mac_accum.sv
// Second pipeline stage: the quire register, the sticky NaR flag and the done pulse.
// Assumes the first stage has already zeroed its bias when no clear is pending.
module quire_mac_accum
    import quire_mac_pkg::*;
#(
    parameter int QW = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  qm_ctl_t              s1_ctl,
    input  logic signed [QW-1:0] s1_prod,
    input  logic signed [QW-1:0] s1_bias,
    output logic signed [QW-1:0] quire_q,
    output logic                 nar_q,
    output logic                 done_q
);
    logic signed [QW-1:0] addend_base;
    logic signed [QW-1:0] sum;
    logic                 ovf;

    // Select the starting value and form the full-width sum.
    always_comb begin
        addend_base = s1_ctl.clear ? s1_bias : quire_q;
        sum         = addend_base + (s1_ctl.valid ? s1_prod : '0);
        ovf         = s1_ctl.valid
                      && (addend_base[QW-1] == s1_prod[QW-1])
                      && (sum[QW-1] != addend_base[QW-1]);
    end

    // Update the quire on clear or on an accepted product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quire_q <= '0;
        end else if (s1_ctl.clear || s1_ctl.valid) begin
            quire_q <= sum;
        end
    end

    // Sticky NaR flag, reloaded by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nar_q <= 1'b0;
        end else if (s1_ctl.clear) begin
            nar_q <= s1_ctl.nar;
        end else if (s1_ctl.nar) begin
            nar_q <= 1'b1;
        end
    end

    // Done follows the last product by one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= s1_ctl.last;
        end
    end

    // R3: adding a product never wraps the quire.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_ctl.valid || s1_ctl.clear) |-> !ovf);

    // R7: the NaR flag only drops on a clear.
    a_r7_nar_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_q && !s1_ctl.clear) |=> nar_q);

    // R9: an idle stage leaves the quire alone.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_ctl.valid && !s1_ctl.clear) |=> $stable(quire_q));
endmodule

// File: rtl/quire_mac.sv
// Exact quire multiply-accumulate unit. Stage 1 forms and aligns the product
// and the bias; stage 2 accumulates. Latency from operand to done is two cycles.
// Assumes decoded operands with scales inside [SCALE_MIN, SCALE_MAX], SCALE_MIN <= 0,
// and runs of at most MAX_TERMS pairs.
module quire_mac
    import quire_mac_pkg::*;
#(
    parameter int SIG_W     = 4,
    parameter int SCALE_W   = 5,
    parameter int SCALE_MIN = -6,
    parameter int SCALE_MAX = 6,
    parameter int MAX_TERMS = 64,
    localparam int QW       = qm_quire_width(MAX_TERMS, SIG_W, SCALE_MAX - SCALE_MIN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_clear,
    input  logic                      in_last,
    input  logic                      a_sign,
    input  logic                      a_zero,
    input  logic                      a_nar,
    input  logic signed [SCALE_W-1:0] a_scale,
    input  logic        [SIG_W-1:0]   a_sig,
    input  logic                      b_sign,
    input  logic                      b_zero,
    input  logic                      b_nar,
    input  logic signed [SCALE_W-1:0] b_scale,
    input  logic        [SIG_W-1:0]   b_sig,
    input  logic                      bias_en,
    input  logic                      bias_sign,
    input  logic signed [SCALE_W-1:0] bias_scale,
    input  logic        [SIG_W-1:0]   bias_sig,
    output logic signed [QW-1:0]      quire_out,
    output logic                      nar_out,
    output logic                      done
);
    logic signed [QW-1:0] prod_al;
    logic signed [QW-1:0] bias_al;
    logic signed [QW-1:0] s1_prod;
    logic signed [QW-1:0] s1_bias;
    qm_ctl_t              s1_ctl;

    quire_mac_mult #(
        .SIG_W(SIG_W), .SCALE_W(SCALE_W), .SCALE_MIN(SCALE_MIN), .QW(QW)
    ) u_mult (
        .a_sign(a_sign), .a_zero(a_zero), .a_nar(a_nar), .a_scale(a_scale), .a_sig(a_sig),
        .b_sign(b_sign), .b_zero(b_zero), .b_nar(b_nar), .b_scale(b_scale), .b_sig(b_sig),
        .prod_al(prod_al)
    );

    quire_mac_bias #(
        .SIG_W(SIG_W), .SCALE_W(SCALE_W), .SCALE_MIN(SCALE_MIN), .QW(QW)
    ) u_bias (
        .bias_en(bias_en), .bias_sign(bias_sign), .bias_scale(bias_scale),
        .bias_sig(bias_sig), .bias_al(bias_al)
    );

    // Stage 1 register: aligned product, aligned bias and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ctl  <= '0;
            s1_prod <= '0;
            s1_bias <= '0;
        end else begin
            s1_ctl.valid <= in_valid;
            s1_ctl.clear <= in_clear;
            s1_ctl.last  <= in_valid && in_last;
            s1_ctl.nar   <= in_valid && (a_nar || b_nar);
            s1_prod      <= in_valid ? prod_al : '0;
            s1_bias      <= in_clear ? bias_al : '0;
        end
    end

    quire_mac_accum #(.QW(QW)) u_accum (
        .clk(clk), .rst_n(rst_n), .s1_ctl(s1_ctl), .s1_prod(s1_prod), .s1_bias(s1_bias),
        .quire_q(quire_out), .nar_q(nar_out), .done_q(done)
    );

    // R5: a last operand is always followed by done two cycles later.
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> ##1 done);

    // R5: done never appears without a last operand two cycles earlier.
    a_r5_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_last, 2));

    // R2: accepted scales stay in the range the alignment is sized for.
    a_r2_scale_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(a_scale) >= SCALE_MIN && int'(a_scale) <= SCALE_MAX
                      && int'(b_scale) >= SCALE_MIN && int'(b_scale) <= SCALE_MAX));
endmodule

// File: tb/quire_mac_tb.sv
module quire_mac_tb;
    localparam int SIG_W = 4, SCALE_W = 5, SMIN = -6, SMAX = 6, TERMS = 64;
    localparam int QW = $clog2(TERMS + 1) + 2 * SIG_W + 2 * (SMAX - SMIN) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_clear = 0, in_last = 0;
    logic a_sign = 0, a_zero = 0, a_nar = 0, b_sign = 0, b_zero = 0, b_nar = 0;
    logic signed [SCALE_W-1:0] a_scale = '0, b_scale = '0, bias_scale = '0;
    logic [SIG_W-1:0] a_sig = '0, b_sig = '0, bias_sig = '0;
    logic bias_en = 0, bias_sign = 0;
    logic signed [QW-1:0] quire_out;
    logic nar_out, done;

    int total = 0, bad = 0;
    bit finished = 0;

    // Stored run operands.
    bit op_as[TERMS], op_az[TERMS], op_an[TERMS], op_bs[TERMS], op_bz[TERMS], op_bn[TERMS];
    int op_asc[TERMS], op_bsc[TERMS], op_asg[TERMS], op_bsg[TERMS];
    bit   rb_en, rb_sign;
    int   rb_sc, rb_sg;

    always #10 clk = ~clk;

    quire_mac u_dut (.*);

    function automatic longint prod_ref(int i);
        longint m;
        if (op_az[i] || op_bz[i] || op_an[i] || op_bn[i]) return 0;
        m = longint'(op_asg[i] * op_bsg[i]) <<< (op_asc[i] + op_bsc[i] - 2 * SMIN);
        return (op_as[i] ^ op_bs[i]) ? -m : m;
    endfunction

    function automatic longint bias_ref();
        longint m;
        if (!rb_en) return 0;
        m = longint'(rb_sg) <<< (rb_sc - 2 * SMIN + SIG_W - 1);
        return rb_sign ? -m : m;
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0 random, 1 max positive, 2 max negative, 3 smallest, 4 random without NaR
    task automatic gen(int i, int mode);
        case (mode)
            1, 2: begin
                op_as[i] = (mode == 2); op_bs[i] = 0; op_az[i] = 0; op_bz[i] = 0;
                op_an[i] = 0; op_bn[i] = 0; op_asc[i] = SMAX; op_bsc[i] = SMAX;
                op_asg[i] = 15; op_bsg[i] = 15;
            end
            3: begin
                op_as[i] = 0; op_bs[i] = 0; op_az[i] = 0; op_bz[i] = 0;
                op_an[i] = 0; op_bn[i] = 0; op_asc[i] = SMIN; op_bsc[i] = SMIN;
                op_asg[i] = 1; op_bsg[i] = 1;
            end
            default: begin
                op_as[i] = 1'($urandom % 2); op_bs[i] = 1'($urandom % 2);
                op_az[i] = ($urandom % 8 == 0); op_bz[i] = ($urandom % 8 == 0);
                op_an[i] = (mode == 0) && ($urandom % 40 == 0);
                op_bn[i] = (mode == 0) && ($urandom % 40 == 0);
                op_asc[i] = SMIN + int'($urandom % (SMAX - SMIN + 1));
                op_bsc[i] = SMIN + int'($urandom % (SMAX - SMIN + 1));
                op_asg[i] = int'($urandom % 16); op_bsg[i] = int'($urandom % 16);
            end
        endcase
    endtask

    task automatic drive_idle_garbage();
        in_valid = 0; in_clear = 0; in_last = 0;
        a_sign = 1'($urandom); a_zero = 0; a_nar = 1'($urandom); b_nar = 1'($urandom);
        a_scale = SCALE_W'(SMAX); b_scale = SCALE_W'(SMAX);
        a_sig = SIG_W'($urandom); b_sig = SIG_W'($urandom); b_sign = 1'($urandom); b_zero = 0;
    endtask

    // Apply a run of n pairs, optionally with idle gaps, then check done, quire and NaR.
    task automatic run(int n, bit gaps, string tag);
        longint exp_q;
        bit     exp_n;
        exp_q = bias_ref(); exp_n = 0;
        for (int i = 0; i < n; i++) begin
            exp_q += prod_ref(i);
            exp_n |= op_an[i] | op_bn[i];
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1; in_clear = (i == 0); in_last = (i == n - 1);
            a_sign = op_as[i]; a_zero = op_az[i]; a_nar = op_an[i];
            a_scale = SCALE_W'(op_asc[i]); a_sig = SIG_W'(op_asg[i]);
            b_sign = op_bs[i]; b_zero = op_bz[i]; b_nar = op_bn[i];
            b_scale = SCALE_W'(op_bsc[i]); b_sig = SIG_W'(op_bsg[i]);
            bias_en = rb_en; bias_sign = rb_sign;
            bias_scale = SCALE_W'(rb_sc); bias_sig = SIG_W'(rb_sg);
            if (gaps && i != n - 1 && ($urandom % 3 == 0)) begin
                @(negedge clk);
                drive_idle_garbage();  // R9: valid low, garbage operands
            end
        end
        @(negedge clk);
        drive_idle_garbage();
        check({tag, " R5 done not early"}, longint'(done), 0);
        @(negedge clk);
        check({tag, " R5 done on time"}, longint'(done), 1);
        check({tag, " R2 R8 quire total"}, longint'(quire_out), exp_q);
        check({tag, " R7 nar flag"}, longint'(nar_out), longint'(exp_n));
        @(negedge clk);
        check({tag, " R5 done one cycle"}, longint'(done), 0);
        check({tag, " R9 R5 quire held"}, longint'(quire_out), exp_q);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d));
        repeat (3) @(negedge clk);
        check("R1 quire reset", longint'(quire_out), 0);
        check("R1 nar reset", longint'(nar_out), 0);
        check("R1 done reset", longint'(done), 0);
        rst_n = 1;

        // R2 single positive product, no bias
        rb_en = 0; rb_sign = 0; rb_sc = 0; rb_sg = 0;
        gen(0, 4); op_az[0] = 0; op_bz[0] = 0; op_as[0] = 0; op_bs[0] = 0;
        op_asg[0] = 13; op_bsg[0] = 11; op_asc[0] = 2; op_bsc[0] = -3;
        run(1, 0, "single");
        // R8 negative single product with positive bias: sign change
        rb_en = 1; rb_sign = 0; rb_sc = 1; rb_sg = 9;
        op_as[0] = 1; run(1, 0, "neg");
        // R4 bias alone through a zero pair (R6)
        rb_en = 1; rb_sign = 1; rb_sc = SMAX; rb_sg = 15;
        op_az[0] = 1; op_asc[0] = SMAX; op_bsc[0] = SMAX; op_asg[0] = 15; op_bsg[0] = 15;
        run(1, 0, "R4 R6 bias only");
        // R6 zero on weight side
        rb_en = 0; op_az[0] = 0; op_bz[0] = 1; run(1, 0, "R6 weight zero");
        // R2 smallest product lands on bit 0
        gen(0, 3); run(1, 0, "R2 smallest");
        // R3 extremes, both signs, full length with max bias
        for (int i = 0; i < TERMS; i++) gen(i, 1);
        rb_en = 1; rb_sign = 0; rb_sc = SMAX; rb_sg = 15;
        run(TERMS, 0, "R3 max pos");
        for (int i = 0; i < TERMS; i++) gen(i, 2);
        rb_sign = 1; run(TERMS, 0, "R3 max neg");
        // R7 NaR set, then cleared by the next run
        for (int i = 0; i < 5; i++) gen(i, 4);
        op_bn[2] = 1; rb_en = 0; run(5, 0, "R7 nar set");
        for (int i = 0; i < 5; i++) gen(i, 4);
        run(5, 0, "R7 nar cleared");
        // Random runs with gaps, biases, zeros and NaRs
        for (int r = 0; r < 30; r++) begin
            int n;
            n = 1 + int'($urandom % TERMS);
            for (int i = 0; i < n; i++) gen(i, 0);
            rb_en = 1'($urandom); rb_sign = 1'($urandom);
            rb_sc = SMIN + int'($urandom % (SMAX - SMIN + 1)); rb_sg = int'($urandom % 16);
            run(n, 1'($urandom), "rand R2 R4 R8 R9");
        end
        // R9 long idle stretch with garbage: quire unchanged
        begin
            longint hold;
            hold = longint'(quire_out);
            repeat (10) begin
                @(negedge clk);
                drive_idle_garbage();
            end
            check("R9 idle hold", longint'(quire_out), hold);
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule